// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two signed two's-complement operands of `W` bits each and returns a signed product of `2W` bits. It has one adder/subtractor, which it uses once per multiplier bit over `W` clock cycles. The multiplicand sits in its own register. A `W+1`-bit accumulator holds the upper half of the running product. The multiplier register holds the lower half. A one-bit register keeps the bit that was last shifted out of the multiplier.

In each iteration the block reads the lowest multiplier bit together with the bit to its right. From that pair it either adds the multiplicand, subtracts it, or leaves the accumulator alone. It then shifts the accumulator and the multiplier register right by one place as a single word, and the shift is arithmetic. Negative multipliers need no fix-up pass after the last iteration.

A client raises `start` for one cycle while `busy` is low. It then waits for the one-cycle `done` pulse and reads `product`, which stays unchanged until the next accepted start.

Top module: `booth_seq_mult`

## Requirements
- R1: During and right after reset, `busy` and `done` are 0 and `product` is 0.
- R2: When `start` is 1 at a rising edge while `busy` is 0, the operands are captured and `busy` is 1 after that edge.
- R3: `busy` stays high for exactly `W` cycles. In the cycle after the last one, `done` is 1 for a single cycle with `busy` 0, and `done` is never 1 while `busy` is 1.
- R4: When `done` is 1, `product` equals the signed product of the captured operands (multiplicand times multiplier, both taken as two's complement and sign-extended to `2W` bits). It keeps that value until the next accepted start.
- R5: Each iteration looks at the pair (current lowest multiplier bit, bit to its right). The pair 1,0 subtracts the multiplicand, 0,1 adds it, and 0,0 or 1,1 leaves the accumulator unchanged. The bit to the right of the first multiplier bit is 0. Random operands of either sign give the exact signed product.
- R6: A multiplier whose bits are all 1 yields the negated multiplicand, sign-extended to `2W` bits.
- R7: The most negative operand times itself yields +2^(2W-2). No bit is lost.
- R8: A `start` seen while `busy` is 1 is ignored. The running operation is not disturbed, no extra `done` pulse appears, and the new operands are never used.
- R9: A zero operand on either side gives a zero product.
- R10: Multipliers with alternating bits (01..01 and 10..10) give exact products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| multiplicand | input | W | Signed multiplicand, captured on accepted start |
| multiplier | input | W | Signed multiplier, captured on accepted start |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2W | Signed product, valid from `done` until the next start |

## Verification
The bound checker watches the handshake on every cycle:
- a start accepted while idle raises `busy`;
- the length of each `busy` run is exactly `W`;
- `done` lasts a single cycle and never overlaps `busy`;
- the product is correct at `done` for the operands captured at the start;
- the product stays stable while idle.

The bench's scenarios are needed for the arithmetic corner cases (all-ones, the most negative square, zero, alternating multipliers). Only those scenarios also show that a start pulse raised during a busy run leaves no trace in the stream of results.

// File: rtl/booth_seq_mult.sv
module booth_seq_mult #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   multiplicand,
  input  logic [W-1:0]   multiplier,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int CW = $clog2(W) + 1;

  logic [W-1:0]  m_reg;
  logic [W:0]    acc;
  logic [W-1:0]  q_reg;
  logic          q_right;
  logic [CW-1:0] iter;

  logic [W:0] m_ext;
  logic [1:0] rec;
  logic [W:0] sum;

  assign m_ext = {m_reg[W-1], m_reg};
  assign rec   = {q_reg[0], q_right};
  assign sum   = (rec == 2'b10) ? acc - m_ext :
                 (rec == 2'b01) ? acc + m_ext : acc;

  assign product = {acc[W-1:0], q_reg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg   <= '0;
      acc     <= '0;
      q_reg   <= '0;
      q_right <= 1'b0;
      iter    <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          m_reg   <= multiplicand;
          acc     <= '0;
          q_reg   <= multiplier;
          q_right <= 1'b0;
          iter    <= '0;
          busy    <= 1'b1;
        end
      end else begin
        acc     <= {sum[W], sum[W:1]};
        q_reg   <= {sum[0], q_reg[W-1:1]};
        q_right <= q_reg[0];
        iter    <= iter + 1'b1;
        if (iter == CW'(W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/booth_seq_mult_chk.sv
module booth_seq_mult_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [W-1:0]   multiplicand,
  input logic [W-1:0]   multiplier,
  input logic           busy,
  input logic           done,
  input logic [2*W-1:0] product
);
  logic [2*W-1:0] want;
  int unsigned    run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want    <= '0;
      run_len <= 0;
    end else begin
      if (start && !busy) begin
        want    <= {{W{multiplicand[W-1]}}, multiplicand} * {{W{multiplier[W-1]}}, multiplier};
        run_len <= 0;
      end else if (busy) begin
        run_len <= run_len + 1;
      end
    end
  end

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done); // R3
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_len == W)); // R3
  AST_PRODUCT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (product == want)); // R4
  AST_PRODUCT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product)); // R4
endmodule

bind booth_seq_mult booth_seq_mult_chk #(.W(W)) u_chk (.*);

// File: tb/test_booth_seq_mult.sv
module test_booth_seq_mult;
  localparam int  W    = 8;
  localparam time TCLK = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic           busy, done;
  logic [2*W-1:0] product;

  int total = 0, bad = 0, issued = 0, finished = 0, run = 0;
  logic [2*W-1:0] exp_q[$];
  string          tag_q[$];
  logic [2*W-1:0] last_exp = '0;

  booth_seq_mult #(.W(W)) i_booth_seq_mult (
    .clk(clk), .rst_n(rst_n), .start(start),
    .multiplicand(mcand), .multiplier(mplier),
    .busy(busy), .done(done), .product(product)
  );

  always #(TCLK/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [2*W-1:0] smul(input logic [W-1:0] a, input logic [W-1:0] b);
    return {{W{a[W-1]}}, a} * {{W{b[W-1]}}, b};
  endfunction

  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    @(negedge clk);
    while (busy) @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    exp_q.push_back(smul(a, b));
    tag_q.push_back(tag);
    issued++;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", {15'd0, busy}, 16'd1);
  endtask

  task automatic drain;
    @(negedge clk);
    while (busy || exp_q.size() != 0) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) run++;
      if (done) begin
        string t;
        logic [2*W-1:0] e;
        chk(run == W, "R3 busy length", 16'(run), 16'(W));
        chk(!busy, "R3 done without busy", {15'd0, busy}, 16'd0);
        run = 0;
        finished++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected done", product, '0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          last_exp = e;
          chk(product == e, t, product, e);
        end
      end
    end
  end

  initial begin
    #(TCLK * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(TCLK * 3);
    @(negedge clk);
    chk(!busy && !done, "R1 reset flags", {14'd0, busy, done}, 16'd0);
    chk(product == '0, "R1 reset product", product, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && product == '0, "R1 after reset", product, '0);

    issue(8'd7, 8'd5, "R5 small positive");
    issue(8'hF9, 8'd5, "R5 negative multiplicand");
    issue(8'd7, 8'hFB, "R5 negative multiplier");
    issue(8'd13, 8'hFF, "R6 all-ones multiplier");
    issue(8'h80, 8'hFF, "R6 all-ones times min");
    issue(8'h80, 8'h80, "R7 min times min");
    issue(8'h7F, 8'h80, "R7 max times min");
    issue(8'd0, 8'h9C, "R9 zero multiplicand");
    issue(8'h9C, 8'd0, "R9 zero multiplier");
    issue(8'h5D, 8'h55, "R10 alternating 0101");
    issue(8'h5D, 8'hAA, "R10 alternating 1010");
    drain();

    repeat (5) @(negedge clk);
    chk(product == last_exp, "R4 product held while idle", product, last_exp);

    issue(8'd3, 8'd9, "R8 first operands kept");
    mcand = 8'h55; mplier = 8'h66; start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    drain();
    chk(finished == issued, "R8 no extra done", 16'(finished), 16'(issued));
    chk(product == 16'd27, "R8 result of first operands", product, 16'd27);

    for (int k = 0; k < 40; k++) begin
      logic [W-1:0] a, b;
      a = W'($urandom);
      b = W'($urandom);
      issue(a, b, "R5 random operands");
    end
    drain();
    chk(finished == issued, "R3 one done per start", 16'(finished), 16'(issued));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule